// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This block turns a program-relative (logical) address into a physical one by adding a base register. It rejects accesses that fall outside the window the limit register grants, and accesses that reach a memory block the requester may not touch. Physical memory is split into fixed-size blocks of 2^BLK_W bytes, 2K by default. Each block has a small protection code, held in an internal table. The table entry for the target block is compared with the access key that arrives with each request. Key zero is a supervisor key that passes every block.

Software loads the base, the limit and the table entries through one write port. A program is moved in memory by rewriting the base register alone; its addresses are never patched. Each request yields a registered result one cycle later. The result is either the physical address, or an error flag with a cause code and a zeroed address.

Top module: `reloc_unit`

## Requirements
- R1: When an access is accepted, the physical address equals base + logical address, taken as PADDR_W bits.
- R2: The relocated address is base + logical, computed one bit wider than PADDR_W. If it is greater than base + limit (computed the same way), or if it reaches 2^PADDR_W, the access is a bounds error. A rejected access reports address 0.
- R3: A write takes effect from the request that follows it. A request in the same cycle as a write still uses the old value. Rewriting the base moves every later translation by the new base.
- R4: The table entry checked is bits [PADDR_W-1:BLK_W] of the relocated address. If the request key is nonzero and differs from that entry, the access is a key error. Key 0 never causes a key error.
- R5: Every request with req_valid high gives exactly one cycle with out_valid high, on the next clock edge. No request gives out_valid low.
- R6: out_cause is 2'b00 for an accepted access, 2'b01 for a bounds error and 2'b10 for a key error. A bounds error wins over a key error. out_err is high exactly when out_cause is nonzero.
- R7: After reset, out_valid is low, base and limit are 0, and every table entry is 0.
- R8: wr_sel 2'b00 loads the base and 2'b01 loads the limit, both from wr_data. wr_sel 2'b10 loads the table entry at wr_idx from wr_data[KEY_W-1:0]. wr_sel 2'b11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: base, limit, table, none |
| wr_idx | input | PADDR_W-BLK_W | Table entry written |
| wr_data | input | PADDR_W | Write value |
| req_valid | input | 1 | Request strobe |
| req_laddr | input | LADDR_W | Logical address |
| req_key | input | KEY_W | Access key of the running process |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | PADDR_W | Physical address, 0 on error |
| out_err | output | 1 | Access rejected |
| out_cause | output | 2 | Cause code |

## Verification
The bench builds the unit with 12-bit physical addresses, 256-byte blocks and a 10-bit logical address. This gives a 16-entry table with one distinct code per block. Every logical address is swept under several base and limit settings, including a base near the top of memory so that the carry out of the sum is exercised. The key sent with each request rotates between supervisor, matching and mismatching values, so all three causes and the priority case are covered. Directed steps then check writes that land in the same cycle as a request, and the ignored write target.

// File: rtl/reloc_pkg.sv
`timescale 1ns/1ps
package reloc_pkg;
  typedef enum logic [1:0] {
    CAUSE_OK     = 2'b00,
    CAUSE_BOUNDS = 2'b01,
    CAUSE_KEY    = 2'b10
  } cause_e;

  localparam logic [1:0] SEL_BASE  = 2'b00;
  localparam logic [1:0] SEL_LIMIT = 2'b01;
  localparam logic [1:0] SEL_KEY   = 2'b10;
endpackage

// File: rtl/reloc_regs.sv
`timescale 1ns/1ps
module reloc_regs #(
  parameter int PADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [PADDR_W-1:0] wr_data,
  output logic [PADDR_W-1:0] base_q,
  output logic [PADDR_W-1:0] limit_q
);
  import reloc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_BASE)  base_q  <= wr_data;
      if (wr_sel == SEL_LIMIT) limit_q <= wr_data;
    end
  end
endmodule

// File: rtl/reloc_key_table.sv
`timescale 1ns/1ps
module reloc_key_table #(
  parameter int IDX_W = 5,
  parameter int KEY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0] rd_key
);
  localparam int NBLK = 1 << IDX_W;

  logic [KEY_W-1:0] entry [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        entry[g] <= wr_key;
    end
  end

  assign rd_key = entry[rd_idx];
endmodule

// File: rtl/reloc_check.sv
`timescale 1ns/1ps
module reloc_check #(
  parameter int LADDR_W = 14,
  parameter int PADDR_W = 16,
  parameter int BLK_W   = 11,
  parameter int KEY_W   = 4
) (
  input  logic [LADDR_W-1:0]       laddr,
  input  logic [PADDR_W-1:0]       base,
  input  logic [PADDR_W-1:0]       limit,
  input  logic [KEY_W-1:0]         acc_key,
  input  logic [KEY_W-1:0]         blk_key,
  output logic [PADDR_W-1:0]       phys,
  output logic [PADDR_W-BLK_W-1:0] blk_idx,
  output logic                     bnd_err,
  output logic                     key_err
);
  localparam int IDX_W = PADDR_W - BLK_W;

  function automatic logic [PADDR_W:0] wide_add(
    input logic [PADDR_W-1:0] a,
    input logic [PADDR_W-1:0] b
  );
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic key_denied(
    input logic [KEY_W-1:0] have,
    input logic [KEY_W-1:0] need
  );
    return (have != '0) && (have != need);
  endfunction

  logic [PADDR_W:0] reloc_w;
  logic [PADDR_W:0] bound_w;

  always_comb begin
    reloc_w = wide_add(base, PADDR_W'(laddr));
    bound_w = wide_add(base, limit);
    phys    = reloc_w[PADDR_W-1:0];
    blk_idx = reloc_w[PADDR_W-1 -: IDX_W];
    bnd_err = (reloc_w > bound_w) || reloc_w[PADDR_W];
    key_err = key_denied(acc_key, blk_key);
  end
endmodule

// File: rtl/reloc_unit.sv
`timescale 1ns/1ps
module reloc_unit #(
  parameter int LADDR_W = 14,
  parameter int PADDR_W = 16,
  parameter int BLK_W   = 11,
  parameter int KEY_W   = 4,
  localparam int IDX_W  = PADDR_W - BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PADDR_W-1:0] wr_data,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_laddr,
  input  logic [KEY_W-1:0]   req_key,
  output logic               out_valid,
  output logic [PADDR_W-1:0] out_addr,
  output logic               out_err,
  output logic [1:0]         out_cause
);
  import reloc_pkg::*;

  logic [PADDR_W-1:0] base_q, limit_q;
  logic [PADDR_W-1:0] phys_w;
  logic [IDX_W-1:0]   blk_idx_w;
  logic [KEY_W-1:0]   blk_key_w;
  logic               bnd_err_w, key_err_w;
  logic               key_wr_w;
  cause_e             cause_w;

  assign key_wr_w = wr_en && (wr_sel == SEL_KEY);

  reloc_regs #(.PADDR_W(PADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .base_q(base_q), .limit_q(limit_q)
  );

  reloc_key_table #(.IDX_W(IDX_W), .KEY_W(KEY_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr_w), .wr_idx(wr_idx),
    .wr_key(wr_data[KEY_W-1:0]), .rd_idx(blk_idx_w), .rd_key(blk_key_w)
  );

  reloc_check #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W), .BLK_W(BLK_W), .KEY_W(KEY_W)) u_check (
    .laddr(req_laddr), .base(base_q), .limit(limit_q), .acc_key(req_key),
    .blk_key(blk_key_w), .phys(phys_w), .blk_idx(blk_idx_w),
    .bnd_err(bnd_err_w), .key_err(key_err_w)
  );

  always_comb begin
    if (bnd_err_w)      cause_w = CAUSE_BOUNDS;
    else if (key_err_w) cause_w = CAUSE_KEY;
    else                cause_w = CAUSE_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
      out_cause <= CAUSE_OK;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_cause <= cause_w;
        out_err   <= (cause_w != CAUSE_OK);
        out_addr  <= (cause_w == CAUSE_OK) ? phys_w : '0;
      end
    end
  end
endmodule

// File: rtl/reloc_unit_chk.sv
`timescale 1ns/1ps
module reloc_unit_chk #(
  parameter int PADDR_W = 16,
  parameter int KEY_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [KEY_W-1:0]   req_key,
  input logic [PADDR_W-1:0] phys_w,
  input logic               bnd_err_w,
  input logic               key_err_w,
  input logic               out_valid,
  input logic [PADDR_W-1:0] out_addr,
  input logic               out_err,
  input logic [1:0]         out_cause
);
  p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  p_accept_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bnd_err_w && !key_err_w) |=> (out_addr == $past(phys_w)) && !out_err);
  p_reject_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_addr == '0));
  p_bounds_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bnd_err_w) |=> (out_cause == 2'b01));
  p_key_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bnd_err_w && key_err_w) |=> (out_cause == 2'b10));
  p_supervisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_key == '0 && !bnd_err_w) |=> !out_err);
  p_err_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_err == (out_cause != 2'b00)) && (out_cause != 2'b11)));
endmodule

bind reloc_unit reloc_unit_chk #(.PADDR_W(PADDR_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
  .phys_w(phys_w), .bnd_err_w(bnd_err_w), .key_err_w(key_err_w),
  .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err),
  .out_cause(out_cause)
);

// File: tb/sim_reloc_unit.sv
`timescale 1ns/1ps
module sim_reloc_unit;
  localparam int LW = 10, PW = 12, BW = 8, KW = 4, IW = PW - BW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [PW-1:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic [LW-1:0] req_laddr = '0;
  logic [KW-1:0] req_key = '0;
  logic out_valid, out_err;
  logic [PW-1:0] out_addr;
  logic [1:0] out_cause;

  int checks = 0, errors = 0;
  logic [PW-1:0] m_base = '0, m_limit = '0;
  logic [KW-1:0] m_keys [1<<IW];

  always #2 clk = ~clk;

  reloc_unit #(.LADDR_W(LW), .PADDR_W(PW), .BLK_W(BW), .KEY_W(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .req_valid(req_valid), .req_laddr(req_laddr),
    .req_key(req_key), .out_valid(out_valid), .out_addr(out_addr),
    .out_err(out_err), .out_cause(out_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic predict(input logic [LW-1:0] la, input logic [KW-1:0] k,
                         output logic [PW-1:0] ea, output logic [1:0] ec);
    int sum, bnd;
    sum = int'(m_base) + int'(la);
    bnd = int'(m_base) + int'(m_limit);
    if (sum > bnd || sum >= (1 << PW)) ec = 2'b01;
    else if (k != 0 && m_keys[sum >> BW] != k) ec = 2'b10;
    else ec = 2'b00;
    ea = (ec == 2'b00) ? PW'(sum) : '0;
  endtask

  task automatic write(input logic [1:0] sel, input logic [IW-1:0] idx, input logic [PW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'b00: m_base = d;
      2'b01: m_limit = d;
      2'b10: m_keys[idx] = d[KW-1:0];
      default: ;
    endcase
  endtask

  task automatic request(input logic [LW-1:0] la, input logic [KW-1:0] k, input string tag);
    logic [PW-1:0] ea;
    logic [1:0] ec;
    predict(la, k, ea, ec);
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la; req_key = k;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R5 valid"}, 32'(out_valid), 32'd1);
    check({tag, " addr"}, 32'(out_addr), 32'(ea));
    check({tag, " R6 cause"}, 32'(out_cause), 32'(ec));
    check({tag, " R6 err"}, 32'(out_err), 32'(ec != 2'b00));
  endtask

  task automatic sweep(input logic [PW-1:0] b, input logic [PW-1:0] l);
    write(2'b00, '0, b);
    write(2'b01, '0, l);
    for (int a = 0; a < (1 << LW); a++) begin
      int blk;
      logic [KW-1:0] k;
      blk = ((int'(b) + a) >> BW) & ((1 << IW) - 1);
      case (a % 3)
        0: k = '0;
        1: k = m_keys[blk];
        default: k = (m_keys[blk] == 4'hF) ? 4'hE : m_keys[blk] + 4'h1;
      endcase
      request(LW'(a), k, "R1 R2 R4 sweep");
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << IW); i++) m_keys[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 out_valid after reset", 32'(out_valid), 32'd0);
    // R7: table zero means any nonzero key mismatches block 0; limit zero allows offset 0 only
    request(10'd0, 4'd5, "R7 reset table");
    request(10'd1, 4'd0, "R7 reset limit");
    @(negedge clk);
    check("R5 idle", 32'(out_valid), 32'd0);

    for (int i = 0; i < (1 << IW); i++) write(2'b10, IW'(i), PW'(i));
    sweep(12'h100, 12'h3FF);
    sweep(12'h000, 12'h1FF);
    sweep(12'hE00, 12'h3FF);
    sweep(12'h7A5, 12'h123);

    // R3: base write and request in the same cycle: request sees old base
    write(2'b01, '0, 12'hFFF);
    write(2'b00, '0, 12'h200);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'b00; wr_data = 12'h500;
    req_valid = 1'b1; req_laddr = 10'h010; req_key = 4'd0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R3 same-cycle old base", 32'(out_addr), 32'h210);
    m_base = 12'h500;
    request(10'h010, 4'd0, "R3 moved base");
    check("R3 moved addr", 32'(out_addr), 32'h510);

    // R3: key write same cycle as a request to that block
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'b10; wr_idx = 4'd5; wr_data = 12'h009;
    req_valid = 1'b1; req_laddr = 10'h020; req_key = 4'd5;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R3 same-cycle old key", 32'(out_cause), 32'd0);
    m_keys[5] = 4'd9;
    request(10'h020, 4'd5, "R3 R4 new key");
    check("R4 new key rejects", 32'(out_cause), 32'd2);

    // R8: selector 3 writes nothing
    write(2'b11, 4'd5, 12'h000);
    request(10'h020, 4'd9, "R8 ignored select key");
    check("R8 key kept", 32'(out_cause), 32'd0);
    request(10'h3FF, 4'd0, "R8 ignored select base");
    check("R8 base kept", 32'(out_addr), 32'h8FF);

    // R2: exact limit edge
    write(2'b01, '0, 12'h0FF);
    request(10'h0FF, 4'd0, "R2 at limit");
    check("R2 at limit ok", 32'(out_err), 32'd0);
    request(10'h100, 4'd0, "R2 past limit");
    check("R2 past limit", 32'(out_cause), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule